// File: doc/BRIEF.md
# Cascaded 32-bit Timer with Cross-Channel Capture

Two 16-bit counting halves form one 32-bit timer. The low half advances by one on every clock in which the count-enable tick is high. It wraps from all ones to zero without stopping. The high half advances only on the clock in which the low half wraps. Each half has its own capture register. On a selected edge of a capture pin, that register latches its half of the count and sets a sticky flag, which stays set until it is cleared by writing 1 to it.

Each half has two routing enables, one per direction. An enable lets the other half's capture pin trigger this half's capture. With routing on, one pin edge latches both halves of the same 32-bit count, even on the clock where the low half wraps. Both pins pass through a synchronizer before edge detection. Edges on a routed pin are qualified by the edge select of the half that receives the capture.

Top module: `ctimer_cascade`

## Requirements
- R1: `cnt_lo` increases by one on each clock edge at which `tick` is 1 and holds otherwise; from 0xFFFF it goes to 0x0000.
- R2: `cnt_hi` increases by one exactly on the clock edge at which `tick` is 1 and `cnt_lo` is 0xFFFF, and holds on every other edge.
- R3: A half's 4-bit edge select works as follows: 4'b1000 picks rising edges, 4'b1001 falling edges and 4'b1010 both edges. Any other code turns capture off. The same select qualifies both the half's own pin and a pin routed into it.
- R4: `cap_hi` latches `cnt_hi` on a selected edge of `pin_hi`. When `xcap_to_hi` is 1, it also latches on a selected edge of `pin_lo`.
- R5: `cap_lo` latches `cnt_lo` on a selected edge of `pin_lo`. An edge of `pin_hi` reaches `cap_lo` only when `xcap_to_lo` is 1; with 0 it leaves `cap_lo` and `flag_lo` untouched.
- R6: When one event captures both halves, `{cap_hi,cap_lo}` equals the 32-bit count of a single clock. This holds even on the clock where the low half wraps, which gives the high value from before the carry and 0xFFFF.
- R7: A pin change driven between clock edges causes its capture on the third rising clock edge after the change. The capture takes the count held just before that edge.
- R8: A capture sets its half's flag. The flag stays set until a clock edge at which the matching clear input is 1 and no capture occurs; a capture on the same edge as a clear wins.
- R9: Synchronous reset sets counters, capture registers, flags and synchronizer stages to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable for the low half |
| pin_lo | input | 1 | Asynchronous capture pin of the low half |
| pin_hi | input | 1 | Asynchronous capture pin of the high half |
| sel_lo | input | 4 | Edge select of the low half |
| sel_hi | input | 4 | Edge select of the high half |
| xcap_to_hi | input | 1 | Route `pin_lo` edges into the high half's capture |
| xcap_to_lo | input | 1 | Route `pin_hi` edges into the low half's capture |
| clr_lo | input | 1 | Clear the low half's flag |
| clr_hi | input | 1 | Clear the high half's flag |
| cnt_lo | output | 16 | Low counter half |
| cnt_hi | output | 16 | High counter half |
| cap_lo | output | 16 | Low capture register |
| cap_hi | output | 16 | High capture register |
| flag_lo | output | 1 | Sticky capture flag, low half |
| flag_hi | output | 1 | Sticky capture flag, high half |

## Verification
The assertions check these rules on every cycle:
- the low half steps or holds with the tick, and the carry into the high half happens only on a wrap;
- capture registers change only after a capture event, and a joint event yields one coherent 32-bit value;
- flags are set, kept and cleared as R8 requires.

The edge-select decoding, the routing enables, the three-edge synchronizer latency and the capture at the exact wrap cycle depend on pin history at the ports. Only the bench's scenarios show those, against its cycle model.

// File: rtl/ctc_pkg.sv
package ctc_pkg;

    localparam int unsigned N_CH  = 2;
    localparam int unsigned CH_LO = 0;
    localparam int unsigned CH_HI = 1;
    localparam int unsigned SEL_W = 4;

    typedef enum logic [SEL_W-1:0] {
        SEL_RISE = 4'b1000,
        SEL_FALL = 4'b1001,
        SEL_BOTH = 4'b1010
    } edge_sel_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } pin_edge_t;

    // Decode an edge-select code against the detected edges of one pin.
    function automatic logic edge_match(input logic [SEL_W-1:0] sel, input pin_edge_t e);
        logic hit;
        case (sel)
            SEL_RISE: hit = e.rise;
            SEL_FALL: hit = e.fall;
            SEL_BOTH: hit = e.rise | e.fall;
            default:  hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/ctc_pin_sync.sv
module ctc_pin_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                pin_i,
    output ctc_pkg::pin_edge_t  edg_o
);
    logic [STAGES-1:0] chain;
    logic              last;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            last  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], pin_i};
            last  <= chain[STAGES-1];
        end
    end

    assign edg_o.rise = chain[STAGES-1] & ~last;
    assign edg_o.fall = ~chain[STAGES-1] & last;
endmodule

// File: rtl/ctc_counter.sv
module ctc_counter #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    output logic [W-1:0] lo_o,
    output logic [W-1:0] hi_o
);
    logic carry;

    assign carry = tick & (&lo_o);

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_o <= '0;
            hi_o <= '0;
        end else begin
            if (tick)  lo_o <= lo_o + 1'b1;
            if (carry) hi_o <= hi_o + 1'b1;
        end
    end
endmodule

// File: rtl/ctc_capture.sv
module ctc_capture #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hit_i,
    input  logic         clr_i,
    input  logic [W-1:0] value_i,
    output logic [W-1:0] cap_o,
    output logic         flag_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cap_o  <= '0;
            flag_o <= 1'b0;
        end else begin
            if (hit_i) cap_o <= value_i;
            flag_o <= hit_i | (flag_o & ~clr_i);
        end
    end
endmodule

// File: rtl/ctimer_cascade.sv
module ctimer_cascade
    import ctc_pkg::*;
#(
    parameter int unsigned HALF_W      = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              pin_lo,
    input  logic              pin_hi,
    input  logic [3:0]        sel_lo,
    input  logic [3:0]        sel_hi,
    input  logic              xcap_to_hi,
    input  logic              xcap_to_lo,
    input  logic              clr_lo,
    input  logic              clr_hi,
    output logic [HALF_W-1:0] cnt_lo,
    output logic [HALF_W-1:0] cnt_hi,
    output logic [HALF_W-1:0] cap_lo,
    output logic [HALF_W-1:0] cap_hi,
    output logic              flag_lo,
    output logic              flag_hi
);
    logic [N_CH-1:0]   pins;
    logic [N_CH-1:0]   xen;
    logic [N_CH-1:0]   clr;
    logic [N_CH-1:0]   ev;
    logic [N_CH-1:0]   flg;
    logic [SEL_W-1:0]  sel  [N_CH];
    logic [HALF_W-1:0] cval [N_CH];
    logic [HALF_W-1:0] capv [N_CH];
    pin_edge_t         pe   [N_CH];

    assign pins        = {pin_hi, pin_lo};
    assign xen         = {xcap_to_hi, xcap_to_lo};
    assign clr         = {clr_hi, clr_lo};
    assign sel[CH_LO]  = sel_lo;
    assign sel[CH_HI]  = sel_hi;
    assign cval[CH_LO] = cnt_lo;
    assign cval[CH_HI] = cnt_hi;

    ctc_counter #(.W(HALF_W)) i_cnt (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .lo_o (cnt_lo),
        .hi_o (cnt_hi)
    );

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        localparam int unsigned OTH = N_CH - 1 - ch;

        ctc_pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
            .clk   (clk),
            .rst   (rst),
            .pin_i (pins[ch]),
            .edg_o (pe[ch])
        );

        // Own pin, or the other half's pin when routed, under this half's select.
        assign ev[ch] = edge_match(sel[ch], pe[ch])
                      | (xen[ch] & edge_match(sel[ch], pe[OTH]));

        ctc_capture #(.W(HALF_W)) i_cap (
            .clk     (clk),
            .rst     (rst),
            .hit_i   (ev[ch]),
            .clr_i   (clr[ch]),
            .value_i (cval[ch]),
            .cap_o   (capv[ch]),
            .flag_o  (flg[ch])
        );
    end

    assign cap_lo  = capv[CH_LO];
    assign cap_hi  = capv[CH_HI];
    assign flag_lo = flg[CH_LO];
    assign flag_hi = flg[CH_HI];
endmodule

// File: rtl/ctimer_cascade_chk.sv
module ctimer_cascade_chk #(
    parameter int unsigned HALF_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              clr_lo,
    input logic              clr_hi,
    input logic [HALF_W-1:0] cnt_lo,
    input logic [HALF_W-1:0] cnt_hi,
    input logic [HALF_W-1:0] cap_lo,
    input logic [HALF_W-1:0] cap_hi,
    input logic              flag_lo,
    input logic              flag_hi,
    input logic [1:0]        ev
);
    a_r1_step: assert property (@(posedge clk) disable iff (rst)
        tick |=> cnt_lo == HALF_W'($past(cnt_lo) + 1'b1));
    a_r1_hold: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt_lo));
    a_r2_carry: assert property (@(posedge clk) disable iff (rst)
        (tick && (&cnt_lo)) |=> cnt_hi == HALF_W'($past(cnt_hi) + 1'b1));
    a_r2_no_carry: assert property (@(posedge clk) disable iff (rst)
        !(tick && (&cnt_lo)) |=> $stable(cnt_hi));
    a_r4_cap_hi: assert property (@(posedge clk) disable iff (rst)
        ev[1] |=> cap_hi == $past(cnt_hi));
    a_r5_cap_lo_quiet: assert property (@(posedge clk) disable iff (rst)
        !ev[0] |=> $stable(cap_lo));
    a_r4_cap_hi_quiet: assert property (@(posedge clk) disable iff (rst)
        !ev[1] |=> $stable(cap_hi));
    a_r6_coherent: assert property (@(posedge clk) disable iff (rst)
        (&ev) |=> (cap_hi == $past(cnt_hi)) && (cap_lo == $past(cnt_lo)));
    a_r8_set_lo: assert property (@(posedge clk) disable iff (rst)
        ev[0] |=> flag_lo);
    a_r8_set_hi: assert property (@(posedge clk) disable iff (rst)
        ev[1] |=> flag_hi);
    a_r8_keep_lo: assert property (@(posedge clk) disable iff (rst)
        (flag_lo && !clr_lo) |=> flag_lo);
    a_r8_clear_lo: assert property (@(posedge clk) disable iff (rst)
        (clr_lo && !ev[0]) |=> !flag_lo);
    a_r8_clear_hi: assert property (@(posedge clk) disable iff (rst)
        (clr_hi && !ev[1]) |=> !flag_hi);
endmodule

bind ctimer_cascade ctimer_cascade_chk #(.HALF_W(HALF_W)) i_chk (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .clr_lo  (clr_lo),
    .clr_hi  (clr_hi),
    .cnt_lo  (cnt_lo),
    .cnt_hi  (cnt_hi),
    .cap_lo  (cap_lo),
    .cap_hi  (cap_hi),
    .flag_lo (flag_lo),
    .flag_hi (flag_hi),
    .ev      (ev)
);

// File: tb/test_ctimer_cascade.sv
module test_ctimer_cascade;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0, pin_lo = 1'b0, pin_hi = 1'b0;
    logic [3:0]  sel_lo = 4'b0, sel_hi = 4'b0;
    logic        xcap_to_hi = 1'b0, xcap_to_lo = 1'b0, clr_lo = 1'b0, clr_hi = 1'b0;
    logic [15:0] cnt_lo, cnt_hi, cap_lo, cap_hi;
    logic        flag_lo, flag_hi;

    int n_chk = 0, n_fail = 0;
    bit running = 1'b0, finished = 1'b0;

    ctimer_cascade i_ctimer_cascade (.*);

    always #(CLK_P/2) clk = ~clk;

    // Cycle model built from the requirements.
    logic [15:0] m_lo = 0, m_hi = 0, m_cap_lo = 0, m_cap_hi = 0;
    logic        m_flag_lo = 0, m_flag_hi = 0;
    logic [1:0]  m_s1 = 0, m_s2 = 0, m_s3 = 0;

    function automatic logic sel_hit(input logic [3:0] s, input logic r, input logic f);
        if (s == 4'b1000) return r;
        if (s == 4'b1001) return f;
        if (s == 4'b1010) return r | f;
        return 1'b0;
    endfunction

    always @(posedge clk) begin
        logic r0, f0, r1, f1, e_lo, e_hi;
        if (rst) begin
            m_lo = 0; m_hi = 0; m_cap_lo = 0; m_cap_hi = 0;
            m_flag_lo = 0; m_flag_hi = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
        end else begin
            r0 = m_s2[0] & ~m_s3[0]; f0 = ~m_s2[0] & m_s3[0];
            r1 = m_s2[1] & ~m_s3[1]; f1 = ~m_s2[1] & m_s3[1];
            e_lo = sel_hit(sel_lo, r0, f0) | (xcap_to_lo & sel_hit(sel_lo, r1, f1));
            e_hi = sel_hit(sel_hi, r1, f1) | (xcap_to_hi & sel_hit(sel_hi, r0, f0));
            if (e_lo) m_cap_lo = m_lo;
            if (e_hi) m_cap_hi = m_hi;
            m_flag_lo = e_lo | (m_flag_lo & ~clr_lo);
            m_flag_hi = e_hi | (m_flag_hi & ~clr_hi);
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = {pin_hi, pin_lo};
            if (tick) begin
                if (m_lo == 16'hFFFF) m_hi = m_hi + 1'b1;
                m_lo = m_lo + 1'b1;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (running && !rst) begin
            chk("R1 cnt_lo", 32'(cnt_lo), 32'(m_lo));
            chk("R2 cnt_hi", 32'(cnt_hi), 32'(m_hi));
            chk("R5 cap_lo", 32'(cap_lo), 32'(m_cap_lo));
            chk("R4 cap_hi", 32'(cap_hi), 32'(m_cap_hi));
            chk("R8 flag_lo", 32'(flag_lo), 32'(m_flag_lo));
            chk("R8 flag_hi", 32'(flag_hi), 32'(m_flag_hi));
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_flags();
        clr_lo = 1'b1; clr_hi = 1'b1;
        step(1);
        clr_lo = 1'b0; clr_hi = 1'b0;
    endtask

    function automatic logic [3:0] rand_sel();
        int k = int'($urandom_range(0, 4));
        if (k == 0) return 4'b1000;
        if (k == 1) return 4'b1001;
        if (k == 2) return 4'b1010;
        return 4'($urandom_range(0, 15));
    endfunction

    task automatic random_phase(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            if (i % 150 == 0) begin
                sel_lo = rand_sel(); sel_hi = rand_sel();
                xcap_to_hi = 1'($urandom_range(0, 1));
                xcap_to_lo = 1'($urandom_range(0, 1));
            end
            tick   = ($urandom_range(0, 3) != 0);
            if ($urandom_range(0, 7) == 0) pin_lo = ~pin_lo;
            if ($urandom_range(0, 7) == 0) pin_hi = ~pin_hi;
            clr_lo = ($urandom_range(0, 15) == 0);
            clr_hi = ($urandom_range(0, 15) == 0);
            step(1);
        end
        clr_lo = 1'b0; clr_hi = 1'b0;
    endtask

    initial begin
        logic [15:0] keep_cap, hi_before;
        void'($urandom(32'd2718));
        step(3);
        chk("R9 reset cnt", {cnt_hi, cnt_lo}, 32'h0);
        chk("R9 reset cap", {cap_hi, cap_lo}, 32'h0);
        chk("R9 reset flags", {30'h0, flag_hi, flag_lo}, 32'h0);
        rst = 1'b0;
        running = 1'b1;

        random_phase(3000);

        // R7 latency and R3 rising select.
        tick = 1'b0; xcap_to_hi = 1'b0; xcap_to_lo = 1'b0;
        pin_lo = 1'b0; pin_hi = 1'b0; sel_lo = 4'b1000; sel_hi = 4'b1000;
        step(5); clear_flags(); step(1);
        pin_lo = 1'b1;
        step(2); chk("R7 no capture before third edge", 32'(flag_lo), 32'h0);
        step(1); chk("R7 capture on third edge", 32'(flag_lo), 32'h1);
        // R3 falling select ignores rising, catches falling.
        sel_lo = 4'b1001; clear_flags(); step(2);
        pin_lo = 1'b0; step(4);
        chk("R3 falling select fires", 32'(flag_lo), 32'h1);
        clear_flags(); pin_lo = 1'b1; step(4);
        chk("R3 falling select ignores rise", 32'(flag_lo), 32'h0);
        // R3 reserved code disables capture.
        sel_lo = 4'b0011; clear_flags(); pin_lo = 1'b0; step(4);
        chk("R3 reserved code no capture", 32'(flag_lo), 32'h0);
        // R5 routing off: pin_hi must not reach the low half.
        sel_lo = 4'b1010; sel_hi = 4'b1000; tick = 1'b1; step(3); clear_flags();
        keep_cap = cap_lo;
        pin_hi = 1'b1; step(4);
        chk("R5 routing off flag_lo", 32'(flag_lo), 32'h0);
        chk("R5 routing off cap_lo", 32'(cap_lo), 32'(keep_cap));
        chk("R4 own pin flag_hi", 32'(flag_hi), 32'h1);
        // R4 routing on: pin_lo reaches the high half.
        xcap_to_hi = 1'b1; sel_hi = 4'b1010; clear_flags();
        pin_lo = 1'b1; step(4);
        chk("R4 routed pin flag_hi", 32'(flag_hi), 32'h1);
        chk("R6 joint capture coherent", {cap_hi, cap_lo}, {m_cap_hi, m_cap_lo});

        // R6 joint capture in the wrap cycle.
        tick = 1'b1; pin_lo = 1'b0; step(4);
        while (cnt_lo != 16'hFFFD) step(1);
        hi_before = cnt_hi;
        pin_lo = 1'b1;
        step(3);
        chk("R6 wrap cycle cap_lo", 32'(cap_lo), 32'h0000FFFF);
        chk("R6 wrap cycle cap_hi", 32'(cap_hi), 32'(hi_before));
        chk("R2 carry after wrap", 32'(cnt_hi), 32'(hi_before + 16'd1));

        random_phase(2000);
        running = 1'b0;
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule